// File: doc/BRIEF.md
# SD Data-Line Timeout Counter

This block guards a data transfer on an SD card bus. While a transfer is in progress it counts SD clock enable pulses. Each time the data lines show activity (a block start, a CRC token, a busy release), the caller pulses a restart input and the count goes back to zero. If the count reaches a window of 2^(e+13) SD clocks with no restart, the block raises a sticky data-timeout error. That flag stays high until software writes a one to clear it.

The window exponent e comes from a 4-bit field. Software derives that field from the card clock frequency, and the largest legal value is 14. An optional workaround input moves the exponent off the values 4, 8 and 12 and uses the next value up instead. The block is built around a three-state controller with these states:

- `ST_IDLE`: no transfer.
- `ST_COUNT`: the window is running.
- `ST_EXPIRED`: the timeout has fired, and counting is frozen until a restart.

The transitions are:

- IDLE→COUNT when the transfer becomes active.
- COUNT→COUNT on a restart.
- COUNT→EXPIRED on the terminal enable.
- EXPIRED→COUNT on a restart.
- Any state→IDLE when the transfer ends.

Top module: `sd_data_timeout`

## Requirements
- R1: After reset, `tmo_err` is 0 and the controller is in the idle state.
- R2: While `xfer_active` is 1, each clock with `sd_clk_en`=1 and `data_evt`=0 counts one enable. `tmo_err` becomes 1 after the clock edge of the 2^(e+BASE)-th counted enable, and not after the one before it. BASE defaults to 13, and e is the effective exponent.
- R3: A `data_evt` pulse restarts the window from zero. An enable in the same cycle as `data_evt` is not counted.
- R4: While `xfer_active` is 0, nothing is counted and the count returns to zero. A new transfer starts a full window.
- R5: `tmo_err` stays 1 until a cycle with `tmo_clr`=1 clears it. If the terminal enable and `tmo_clr` arrive in the same cycle, the flag is set.
- R6: A `tmo_exp` value of 15 is treated as 14.
- R7: With `errata_fix_en`=1, exponent values 4, 8 and 12 are replaced by 5, 9 and 13. Other values are used unchanged. With `errata_fix_en`=0, every value up to 14 is used as given.
- R8: After a timeout, further enables are not counted and cannot raise the flag again. A `data_evt` starts a fresh full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_clk_en | input | 1 | One-cycle pulse per SD card clock |
| xfer_active | input | 1 | High while a data transfer is in progress |
| data_evt | input | 1 | Restart pulse on each data-line event |
| tmo_exp | input | 4 | Window exponent e (window = 2^(e+BASE) SD clocks) |
| errata_fix_en | input | 1 | Skip exponents 4, 8, 12 when high |
| tmo_clr | input | 1 | Write-one-to-clear for the timeout flag |
| tmo_err | output | 1 | Sticky data-timeout error flag |

## Verification
The hardest situation to reach is the exact terminal enable. At the default BASE the smallest window is 8192 enables and the largest is 2^27, which is far beyond any bench budget.

The bench therefore builds the block with BASE set to 1. This keeps the exponent arithmetic, the clamping and the workaround mapping unchanged, and it shrinks the windows enough to walk each one enable by enable. For each window the bench checks the edge just before the terminal enable and the terminal edge itself.

Two coincidences are driven on purpose: a restart together with an enable, and a clear together with the terminal enable.

// File: rtl/sd_dto_pkg.sv
package sd_dto_pkg;

    // Controller states of the data timeout watcher.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } dto_state_e;

    // Largest legal window exponent.
    localparam int unsigned DTO_MAX_EXP = 14;

    // Exponent field width.
    localparam int unsigned DTO_EXP_W = 4;

endpackage

// File: rtl/sd_dto_exp_resolve.sv
module sd_dto_exp_resolve
    import sd_dto_pkg::*;
#(
    parameter int unsigned EXP_W   = DTO_EXP_W,
    parameter int unsigned MAX_EXP = DTO_MAX_EXP,
    parameter int unsigned BASE    = 13,
    parameter int unsigned CNT_W   = MAX_EXP + BASE
) (
    input  logic [EXP_W-1:0] raw_exp,
    input  logic             fix_en,
    output logic [EXP_W-1:0] eff_exp,
    output logic [CNT_W-1:0] term_cnt
);

    logic [EXP_W-1:0] clamped;
    logic             skip_hit;

    // Saturate out-of-range codes to the maximum exponent.
    always_comb begin
        if (raw_exp > EXP_W'(MAX_EXP)) begin
            clamped = EXP_W'(MAX_EXP);
        end else begin
            clamped = raw_exp;
        end
    end

    // The workaround avoids the nonzero multiples of four below the maximum.
    always_comb begin
        skip_hit = fix_en
                && (clamped != '0)
                && (clamped[1:0] == 2'b00)
                && (clamped < EXP_W'(MAX_EXP));
    end

    always_comb begin
        if (skip_hit) begin
            eff_exp = clamped + EXP_W'(1);
        end else begin
            eff_exp = clamped;
        end
    end

    // Terminal count is one less than the window length.
    always_comb begin
        term_cnt = CNT_W'((64'd1 << (int'(eff_exp) + int'(BASE))) - 64'd1);
    end

endmodule

// File: rtl/sd_dto_counter.sv
module sd_dto_counter #(
    parameter int unsigned CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] term_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    // The terminal enable is the one that finds the count at its last value.
    always_comb begin
        hit = inc && (cnt == term_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc) begin
            if (hit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R3: a clear request leaves the count at zero on the next cycle.
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

endmodule

// File: rtl/sd_dto_fsm.sv
module sd_dto_fsm
    import sd_dto_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tick,
    input  logic       restart,
    input  logic       hit,
    input  logic       clr,
    output logic       cnt_clear,
    output logic       cnt_inc,
    output logic       flag,
    output dto_state_e state
);

    dto_state_e state_nx;
    logic       flag_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (active) begin
                    state_nx = hit ? ST_EXPIRED : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!active) begin
                    state_nx = ST_IDLE;
                end else if (restart) begin
                    state_nx = ST_COUNT;
                end else if (hit) begin
                    state_nx = ST_EXPIRED;
                end
            end
            ST_EXPIRED: begin
                if (!active) begin
                    state_nx = ST_IDLE;
                end else if (restart) begin
                    state_nx = ST_COUNT;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Counter controls and flag update.
    always_comb begin
        cnt_clear = !active || restart;
        cnt_inc   = 1'b0;
        unique case (state)
            ST_IDLE:    cnt_inc = active && tick && !restart;
            ST_COUNT:   cnt_inc = active && tick && !restart;
            ST_EXPIRED: cnt_inc = 1'b0;
            default:    cnt_inc = 1'b0;
        endcase
        if (hit) begin
            flag_nx = 1'b1;
        end else if (clr) begin
            flag_nx = 1'b0;
        end else begin
            flag_nx = flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= flag_nx;
        end
    end

    // R5: the flag holds without a clear.
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R2: the flag only rises on a terminal enable.
    p_rise_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));

    // R4: an idle transfer parks the controller.
    p_inactive_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_IDLE));

endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout
    import sd_dto_pkg::*;
#(
    parameter int unsigned BASE = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sd_clk_en,
    input  logic       xfer_active,
    input  logic       data_evt,
    input  logic [3:0] tmo_exp,
    input  logic       errata_fix_en,
    input  logic       tmo_clr,
    output logic       tmo_err
);

    localparam int unsigned CNT_W = DTO_MAX_EXP + BASE;

    logic [3:0]       eff_exp;
    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             cnt_clear;
    logic             cnt_inc;
    dto_state_e       state;

    sd_dto_exp_resolve #(
        .EXP_W  (4),
        .MAX_EXP(DTO_MAX_EXP),
        .BASE   (BASE),
        .CNT_W  (CNT_W)
    ) u_exp (
        .raw_exp (tmo_exp),
        .fix_en  (errata_fix_en),
        .eff_exp (eff_exp),
        .term_cnt(term_cnt)
    );

    sd_dto_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .inc     (cnt_inc),
        .term_cnt(term_cnt),
        .cnt     (cnt),
        .hit     (hit)
    );

    sd_dto_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (xfer_active),
        .tick     (sd_clk_en),
        .restart  (data_evt),
        .hit      (hit),
        .clr      (tmo_clr),
        .cnt_clear(cnt_clear),
        .cnt_inc  (cnt_inc),
        .flag     (tmo_err),
        .state    (state)
    );

    // R8: once expired, the count is frozen until a restart or the transfer ends.
    p_expired_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED && xfer_active && !data_evt) |=> $stable(cnt));

    // R1: the controller leaves reset idle with no error.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !tmo_err));

endmodule

// File: tb/sd_data_timeout_tb_top.sv
module sd_data_timeout_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sd_clk_en;
    logic       xfer_active;
    logic       data_evt;
    logic [3:0] tmo_exp;
    logic       errata_fix_en;
    logic       tmo_clr;
    logic       tmo_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic  exp_flag;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2.5 clk = ~clk;

    sd_data_timeout #(.BASE(1)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sd_clk_en    (sd_clk_en),
        .xfer_active  (xfer_active),
        .data_evt     (data_evt),
        .tmo_exp      (tmo_exp),
        .errata_fix_en(errata_fix_en),
        .tmo_clr      (tmo_clr),
        .tmo_err      (tmo_err)
    );

    // Monitor: one expectation per clock edge, compared after the edge settles.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (tmo_err !== it.exp_flag) begin
                fails++;
                $display("FAIL %s: tmo_err=%0b expected=%0b", it.tag, tmo_err, it.exp_flag);
            end
        end
    end

    // Pushed at a negedge: this is the value expected after the next posedge.
    task automatic push(input logic e, input string tag);
        exp_item_t it;
        it.exp_flag = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic check_now(input logic e, input string tag);
        @(negedge clk);
        push(e, tag);
    endtask

    // Drive n enables with gap idle cycles after each one.
    // Checks the flag after enable n-1 (ep) and after enable n (el).
    task automatic run(input int n, input int gap, input logic ep, input logic el,
                       input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sd_clk_en = 1'b1;
            if (i == n - 2) push(ep, tag);
            if (i == n - 1) push(el, tag);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                sd_clk_en = 1'b0;
            end
        end
        @(negedge clk);
        sd_clk_en = 1'b0;
    endtask

    task automatic new_window();
        @(negedge clk);
        tmo_clr  = 1'b1;
        data_evt = 1'b1;
        @(negedge clk);
        tmo_clr  = 1'b0;
        data_evt = 1'b0;
    endtask

    task automatic wait_drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n         = 1'b0;
        sd_clk_en     = 1'b0;
        xfer_active   = 1'b0;
        data_evt      = 1'b0;
        tmo_exp       = 4'd2;
        errata_fix_en = 1'b0;
        tmo_clr       = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_now(1'b0, "R1");

        // R2: e=2 -> 8 enables, spaced by idle cycles
        @(negedge clk);
        xfer_active = 1'b1;
        run(8, 1, 1'b0, 1'b1, "R2");
        // R2: continuous enables, same window
        new_window();
        run(8, 0, 1'b0, 1'b1, "R2");

        // R5: sticky without clear, then cleared by a write of 1
        repeat (5) @(negedge clk);
        check_now(1'b1, "R5");
        @(negedge clk);
        tmo_clr = 1'b1;
        push(1'b0, "R5");
        @(negedge clk);
        tmo_clr = 1'b0;

        // R8: expired, enables ignored; then restart gives a full window
        run(20, 0, 1'b0, 1'b0, "R8");
        @(negedge clk);
        data_evt = 1'b1;
        @(negedge clk);
        data_evt = 1'b0;
        run(8, 0, 1'b0, 1'b1, "R8");

        // R3: restart mid-window, and restart coinciding with an enable
        new_window();
        run(6, 0, 1'b0, 1'b0, "R3");
        @(negedge clk);
        data_evt  = 1'b1;
        sd_clk_en = 1'b1;
        @(negedge clk);
        data_evt  = 1'b0;
        sd_clk_en = 1'b0;
        run(7, 0, 1'b0, 1'b0, "R3");
        run(1, 0, 1'b0, 1'b1, "R3");

        // R4: inactive period discards count and ignores enables
        new_window();
        run(5, 0, 1'b0, 1'b0, "R4");
        @(negedge clk);
        xfer_active = 1'b0;
        sd_clk_en   = 1'b1;
        repeat (19) @(negedge clk);
        push(1'b0, "R4");
        @(negedge clk);
        sd_clk_en   = 1'b0;
        xfer_active = 1'b1;
        run(7, 0, 1'b0, 1'b0, "R4");
        run(1, 0, 1'b0, 1'b1, "R4");

        // R5: clear coinciding with the terminal enable -> set wins
        new_window();
        run(7, 0, 1'b0, 1'b0, "R5");
        @(negedge clk);
        sd_clk_en = 1'b1;
        tmo_clr   = 1'b1;
        push(1'b1, "R5");
        @(negedge clk);
        sd_clk_en = 1'b0;
        tmo_clr   = 1'b0;

        // R7: e=4 without the fix -> 32
        wait_drain();
        tmo_exp = 4'd4;
        new_window();
        run(32, 0, 1'b0, 1'b1, "R7");
        // R7: e=4 with the fix -> 5 -> 64
        wait_drain();
        errata_fix_en = 1'b1;
        new_window();
        run(64, 0, 1'b0, 1'b1, "R7");
        // R7: e=3 with the fix -> unchanged -> 16
        wait_drain();
        tmo_exp = 4'd3;
        new_window();
        run(16, 0, 1'b0, 1'b1, "R7");
        // R7: e=8 with the fix -> 9 -> 1024
        wait_drain();
        tmo_exp = 4'd8;
        new_window();
        run(1024, 0, 1'b0, 1'b1, "R7");
        // R7: e=12 with the fix -> 13 -> 16384
        wait_drain();
        tmo_exp = 4'd12;
        new_window();
        run(16384, 0, 1'b0, 1'b1, "R7");

        // R6: e=15 -> 14 -> 32768
        wait_drain();
        errata_fix_en = 1'b0;
        tmo_exp = 4'd15;
        new_window();
        run(32768, 0, 1'b0, 1'b1, "R6");

        wait_drain();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule